// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the feedback divider (N), reference divider (M) and post divider (PL) of a running clock PLL without a glitch on the clock it drives. A request carries the new coefficients. If the PLL is running and only N differs, the block hands one ramp to an external ramp controller and stops there. Any other change runs the full sequence. First N is ramped down to the divider that gives the lowest VCO frequency. The output divider is then set to 1:2 so that the step to the bypass clock is halved. The output is switched to bypass, and the PLL is powered up if needed, disabled, loaded and re-enabled. After lock the output goes back to the VCO at 1:1 and N is ramped up to its target.

If any step of a ramped attempt times out (a ramp or the lock wait), the block retries the whole sequence once. The retry does no ramps and loads the final N directly. A separate shutdown request ramps N down, selects bypass and disables the PLL. The block owns the PLL control fields (coefficients, enable, power-down, lock-detect disable, output select and output divider). A ramp controller outside the block moves the analog N and signals completion. All waits are counted in clock cycles set by parameters.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset: enable 0, power-down 1, lock-detect-off 1, output select 0 (bypass), output divider code 0 (1:1), all coefficients 0, busy 0, done 0.
- R2: A program request with the PLL enabled and new M and PL equal to the current ones performs exactly one ramp (coef_n set to the new N while ramp_go is high) and no bypass or divider change; M and PL stay stable during any ramp.
- R3: Any ramp whose target equals the current coef_n is skipped: no ramp_go pulse.
- R4: Any other program request, when the PLL is enabled, first ramps N to the minimum-VCO divider of the old M, ceil(M×VCO_MIN/REF_MHZ) saturated at 255 (84, 167, 250 and 255 for M = 1..4 at 1000/12). It then sets the output divider code to 2 (1:2), waits at least WAIT_CYC cycles and selects bypass.
- R5: After bypass, a set power-down bit is cleared, followed by at least WAIT_CYC cycles. The PLL is then disabled and loaded with the new M and PL, and with N = the minimum-VCO divider of the new M (or the target N on a retry). Next, enable is set and lock-detect-off is cleared. Coefficients change only while the PLL is disabled.
- R6: The output select goes to the VCO only after lock is seen. The divider code returns to 0 at least WAIT_CYC cycles later, and N is then ramped to the target.
- R7: If lock is not seen within LOCK_TO cycles on the ramped attempt, the sequence is retried once without ramps. If the retry also fails, the status is 1 (lock timeout) and the output stays on bypass.
- R8: If ramp_done is not seen within RAMP_TO cycles during a program, the sequence is retried without ramps. The final N is loaded directly and the status is 0 when lock follows.
- R9: A shutdown request with the PLL enabled ramps N to the minimum-VCO divider of the current M, then selects bypass, then clears enable. With the PLL disabled it ramps nothing. A ramp timeout gives status 2 and the shutdown still completes. Output select is never 1 while enable is 0.
- R10: A request while busy has no effect and raises refused for one cycle.
- R11: Completion raises done for exactly one cycle, with status 0 (success), 1 (lock timeout) or 2 (ramp timeout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_prog | input | 1 | Program request pulse |
| req_shut | input | 1 | Shutdown request pulse |
| tgt_m | input | M_W | New reference divider |
| tgt_n | input | N_W | New feedback divider |
| tgt_pl | input | PL_W | New post-divider code |
| busy | output | 1 | Sequence in progress |
| refused | output | 1 | Request dropped because busy |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code |
| coef_m | output | M_W | Applied M |
| coef_n | output | N_W | Applied N, also the ramp target |
| coef_pl | output | PL_W | Applied PL |
| pll_en | output | 1 | PLL enable |
| pll_iddq | output | 1 | PLL power-down |
| lockdet_off | output | 1 | Lock detector disable |
| pll_lock | input | 1 | PLL lock indication |
| vco_sel | output | 1 | Output select: 1 VCO, 0 bypass |
| out_div | output | DIV_W | Output divider code, 0 = 1:1, 2 = 1:2 |
| ramp_go | output | 1 | Ramp controller request, held during ramp |
| ramp_done | input | 1 | Ramp controller completion |

## Verification
The bench compares the ordered list of ramp targets against a reference path model. A design that forgot the ramp-down or ramped when the target already matched would produce a different list. Timestamps of divider, select, power-down and enable edges catch a sequencer that switches to bypass before the 1:2 divide or shortens a settle wait. Broken lock and ramp models drive the retry paths: a wrong design would ramp again on the retry, report the wrong status, or leave the output on the VCO. A request issued while busy must leave the coefficients of the first request in place.

// File: rtl/pllseq_pkg.sv
// Shared types for the PLL reprogramming sequencer.
// Assumes: divider code 0 means 1:1 and code 2 means 1:2.
package pllseq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RAMP, S_DIV2, S_BYPW, S_IDDQW, S_PROG,
        S_ENA, S_LOCK, S_VCOW, S_SHBYP, S_SHOFF, S_FIN
    } seq_st_t;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_LOCK = 2'd1,
        RES_RAMP = 2'd2
    } seq_res_t;

    localparam int DIV_ONE  = 0;
    localparam int DIV_HALF = 2;
endpackage

// File: rtl/pllseq_nlo.sv
// Minimum-VCO feedback divider: ceil(m * VCO_MIN / REF_MHZ), saturated
// to the N field width. Purely combinational; assumes REF_MHZ > 0.
module pllseq_nlo #(
    parameter int M_W     = 8,
    parameter int N_W     = 8,
    parameter int VCO_MIN = 1000,
    parameter int REF_MHZ = 12
) (
    input  logic [M_W-1:0] m,
    output logic [N_W-1:0] n_lo
);
    localparam int NMAX = (1 << N_W) - 1;
    logic [31:0] quot;

    // Ceiling divide then saturate.
    always_comb begin
        quot = (32'(m) * 32'(VCO_MIN) + 32'(REF_MHZ - 1)) / 32'(REF_MHZ);
        n_lo = (quot > 32'(NMAX)) ? N_W'(NMAX) : quot[N_W-1:0];
    end
endmodule

// File: rtl/pll_reprog_seq.sv
// PLL reprogramming sequencer. Accepts one program or shutdown request
// at a time and walks the PLL control fields through a glitch-free
// order: ramp down, 1:2 divide, bypass, reload, lock, VCO, 1:1, ramp up.
// A failed ramped attempt is retried once without ramps.
// Assumes an external ramp controller follows coef_n while ramp_go is high.
module pll_reprog_seq
    import pllseq_pkg::*;
#(
    parameter int M_W      = 8,
    parameter int N_W      = 8,
    parameter int PL_W     = 6,
    parameter int DIV_W    = 6,
    parameter int REF_MHZ  = 12,
    parameter int VCO_MIN  = 1000,
    parameter int WAIT_CYC = 200,
    parameter int LOCK_TO  = 30000,
    parameter int RAMP_TO  = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_prog,
    input  logic             req_shut,
    input  logic [M_W-1:0]   tgt_m,
    input  logic [N_W-1:0]   tgt_n,
    input  logic [PL_W-1:0]  tgt_pl,
    output logic             busy,
    output logic             refused,
    output logic             done,
    output logic [1:0]       status,
    output logic [M_W-1:0]   coef_m,
    output logic [N_W-1:0]   coef_n,
    output logic [PL_W-1:0]  coef_pl,
    output logic             pll_en,
    output logic             pll_iddq,
    output logic             lockdet_off,
    input  logic             pll_lock,
    output logic             vco_sel,
    output logic [DIV_W-1:0] out_div,
    output logic             ramp_go,
    input  logic             ramp_done
);
    localparam int LIM_A = (WAIT_CYC > LOCK_TO) ? WAIT_CYC : LOCK_TO;
    localparam int LIM   = (LIM_A > RAMP_TO) ? LIM_A : RAMP_TO;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam logic [CNT_W-1:0] T_WAIT = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] T_LOCK = CNT_W'(LOCK_TO - 1);
    localparam logic [CNT_W-1:0] T_RAMP = CNT_W'(RAMP_TO - 1);

    seq_st_t           st, ramp_nxt;
    logic [CNT_W-1:0]  tcnt;
    logic [M_W-1:0]    tm;
    logic [N_W-1:0]    tn;
    logic [PL_W-1:0]   tpl;
    logic              try_ramp, shut;
    logic [N_W-1:0]    n_lo_old, n_lo_new;

    pllseq_nlo #(.M_W(M_W), .N_W(N_W), .VCO_MIN(VCO_MIN), .REF_MHZ(REF_MHZ))
        u_nlo_old (.m(coef_m), .n_lo(n_lo_old));
    pllseq_nlo #(.M_W(M_W), .N_W(N_W), .VCO_MIN(VCO_MIN), .REF_MHZ(REF_MHZ))
        u_nlo_new (.m(tm), .n_lo(n_lo_new));

    // State decodes seen by the outside.
    assign busy    = (st != S_IDLE);
    assign ramp_go = (st == S_RAMP);

    // Sequencer: state, cycle timer and every PLL control field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;           ramp_nxt <= S_IDLE;
            tcnt <= '0;             tm <= '0; tn <= '0; tpl <= '0;
            try_ramp <= 1'b0;       shut <= 1'b0;
            done <= 1'b0;           refused <= 1'b0;
            status <= RES_OK;
            coef_m <= '0;           coef_n <= '0; coef_pl <= '0;
            pll_en <= 1'b0;         pll_iddq <= 1'b1; lockdet_off <= 1'b1;
            vco_sel <= 1'b0;        out_div <= DIV_W'(DIV_ONE);
        end else begin
            done    <= 1'b0;
            refused <= (req_prog | req_shut) && (st != S_IDLE);
            if (tcnt != {CNT_W{1'b1}}) tcnt <= tcnt + 1'b1;
            case (st)
                S_IDLE: begin
                    if (req_prog) begin
                        tm <= tgt_m; tn <= tgt_n; tpl <= tgt_pl;
                        try_ramp <= 1'b1; shut <= 1'b0;
                        status <= RES_OK; tcnt <= '0;
                        if (pll_en && tgt_m == coef_m && tgt_pl == coef_pl) begin
                            if (tgt_n == coef_n) st <= S_FIN;
                            else begin
                                coef_n <= tgt_n; ramp_nxt <= S_FIN; st <= S_RAMP;
                            end
                        end else if (pll_en && n_lo_old != coef_n) begin
                            coef_n <= n_lo_old; ramp_nxt <= S_DIV2; st <= S_RAMP;
                        end else begin
                            st <= S_DIV2;
                        end
                    end else if (req_shut) begin
                        shut <= 1'b1; status <= RES_OK; tcnt <= '0;
                        if (pll_en && n_lo_old != coef_n) begin
                            coef_n <= n_lo_old; ramp_nxt <= S_SHBYP; st <= S_RAMP;
                        end else begin
                            st <= S_SHBYP;
                        end
                    end
                end
                S_RAMP: begin
                    if (ramp_done) begin
                        st <= ramp_nxt; tcnt <= '0;
                    end else if (tcnt == T_RAMP) begin
                        tcnt <= '0;
                        if (shut) begin
                            status <= RES_RAMP; st <= ramp_nxt;
                        end else begin
                            try_ramp <= 1'b0; st <= S_DIV2;
                        end
                    end
                end
                S_DIV2: begin
                    out_div <= DIV_W'(DIV_HALF); st <= S_BYPW; tcnt <= '0;
                end
                S_BYPW: begin
                    if (tcnt == T_WAIT) begin
                        vco_sel <= 1'b0; tcnt <= '0;
                        if (pll_iddq) begin
                            pll_iddq <= 1'b0; st <= S_IDDQW;
                        end else begin
                            st <= S_PROG;
                        end
                    end
                end
                S_IDDQW: begin
                    if (tcnt == T_WAIT) begin
                        st <= S_PROG; tcnt <= '0;
                    end
                end
                S_PROG: begin
                    pll_en  <= 1'b0;
                    coef_m  <= tm;
                    coef_pl <= tpl;
                    coef_n  <= try_ramp ? n_lo_new : tn;
                    st <= S_ENA; tcnt <= '0;
                end
                S_ENA: begin
                    pll_en <= 1'b1; lockdet_off <= 1'b0;
                    st <= S_LOCK; tcnt <= '0;
                end
                S_LOCK: begin
                    if (pll_lock) begin
                        vco_sel <= 1'b1; st <= S_VCOW; tcnt <= '0;
                    end else if (tcnt == T_LOCK) begin
                        tcnt <= '0;
                        if (try_ramp) begin
                            try_ramp <= 1'b0; st <= S_DIV2;
                        end else begin
                            status <= RES_LOCK; st <= S_FIN;
                        end
                    end
                end
                S_VCOW: begin
                    if (tcnt == T_WAIT) begin
                        out_div <= DIV_W'(DIV_ONE); tcnt <= '0;
                        if (try_ramp && tn != coef_n) begin
                            coef_n <= tn; ramp_nxt <= S_FIN; st <= S_RAMP;
                        end else begin
                            st <= S_FIN;
                        end
                    end
                end
                S_SHBYP: begin
                    vco_sel <= 1'b0; st <= S_SHOFF;
                end
                S_SHOFF: begin
                    pll_en <= 1'b0; st <= S_FIN;
                end
                S_FIN: begin
                    done <= 1'b1; st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
// Temporal checks on the sequencer's ports, bound to every instance.
module pll_reprog_seq_chk #(
    parameter int M_W  = 8,
    parameter int PL_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            refused,
    input logic            done,
    input logic [M_W-1:0]  coef_m,
    input logic [PL_W-1:0] coef_pl,
    input logic            pll_en,
    input logic            pll_lock,
    input logic            vco_sel,
    input logic            ramp_go
);
    a_r2_ramp_holds_mpl: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_go |-> ($stable(coef_m) && $stable(coef_pl)));
    a_r5_reload_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(coef_m) |-> !pll_en);
    a_r6_vco_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_sel) |-> $past(pll_lock));
    a_r9_bypass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> !vco_sel);
    a_r10_refuse_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        refused |-> $past(busy));
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.M_W(M_W), .PL_W(PL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .refused(refused), .done(done),
    .coef_m(coef_m), .coef_pl(coef_pl), .pll_en(pll_en), .pll_lock(pll_lock),
    .vco_sel(vco_sel), .ramp_go(ramp_go)
);

// File: tb/pll_reprog_seq_bench.sv
// Bench: directed corner cases then seeded random programs, with a PLL
// lock model and a ramp controller model that can each be broken.
module pll_reprog_seq_bench;
    localparam int WAIT = 6;
    localparam int LTO  = 40;
    localparam int RTO  = 30;
    localparam int LDLY = 8;
    localparam int RDLY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_prog = 1'b0, req_shut = 1'b0;
    logic [7:0] tgt_m = '0, tgt_n = '0;
    logic [5:0] tgt_pl = '0;
    logic busy, refused, done;
    logic [1:0] status;
    logic [7:0] coef_m, coef_n;
    logic [5:0] coef_pl, out_div;
    logic pll_en, pll_iddq, lockdet_off, vco_sel, ramp_go;
    logic pll_lock = 1'b0, ramp_done = 1'b0;

    pll_reprog_seq #(.WAIT_CYC(WAIT), .LOCK_TO(LTO), .RAMP_TO(RTO)) u_pll_reprog_seq (
        .clk(clk), .rst_n(rst_n), .req_prog(req_prog), .req_shut(req_shut),
        .tgt_m(tgt_m), .tgt_n(tgt_n), .tgt_pl(tgt_pl), .busy(busy),
        .refused(refused), .done(done), .status(status), .coef_m(coef_m),
        .coef_n(coef_n), .coef_pl(coef_pl), .pll_en(pll_en), .pll_iddq(pll_iddq),
        .lockdet_off(lockdet_off), .pll_lock(pll_lock), .vco_sel(vco_sel),
        .out_div(out_div), .ramp_go(ramp_go), .ramp_done(ramp_done));

    always #5 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    bit lock_broken = 0, ramp_broken = 0;
    int lcnt = 0, rcnt = 0;

    // PLL and ramp controller models, updated away from the active edge.
    always @(negedge clk) begin
        lcnt = pll_en ? lcnt + 1 : 0;
        pll_lock <= pll_en && lcnt >= LDLY && !lock_broken;
        rcnt = ramp_go ? rcnt + 1 : 0;
        ramp_done <= ramp_go && rcnt == RDLY && !ramp_broken;
    end

    // Event log of port transitions.
    int rl[8]; int nr;
    int t_div2, t_div1, t_byp, t_vco, t_iddq, t_enr, t_enf, n_enr;
    logic p_go = 0, p_vco = 0, p_iddq = 1, p_en = 0;
    logic [5:0] p_div = 0;
    always @(negedge clk) begin
        cyc++;
        if (ramp_go && !p_go) begin if (nr < 8) rl[nr] = coef_n; nr++; end
        if (out_div == 2 && p_div != 2) t_div2 = cyc;
        if (out_div == 0 && p_div == 2) t_div1 = cyc;
        if (!vco_sel && p_vco) t_byp = cyc;
        if (vco_sel && !p_vco) t_vco = cyc;
        if (!pll_iddq && p_iddq) t_iddq = cyc;
        if (pll_en && !p_en) begin t_enr = cyc; n_enr = coef_n; end
        if (!pll_en && p_en) t_enf = cyc;
        p_go = ramp_go; p_vco = vco_sel; p_iddq = pll_iddq; p_en = pll_en; p_div = out_div;
    end

    function automatic int nlo(int m);
        int q = (m * 1000 + 11) / 12;
        return (q > 255) ? 255 : q;
    endfunction

    task automatic chk(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic clear_log();
        nr = 0; t_div2 = -1; t_div1 = -1; t_byp = -1; t_vco = -1;
        t_iddq = -1; t_enr = -1; t_enf = -1; n_enr = -1;
    endtask

    task automatic wait_done(string r);
        int k = 0;
        while (!done && k < 3000) begin @(negedge clk); k++; end
        if (!done) chk({r, " watchdog"}, 0, 1);
    endtask

    task automatic fire(bit shut, int m, int n, int pl);
        @(negedge clk);
        clear_log();
        tgt_m = 8'(m); tgt_n = 8'(n); tgt_pl = 6'(pl);
        if (shut) req_shut = 1; else req_prog = 1;
        @(negedge clk);
        req_prog = 0; req_shut = 0;
    endtask

    task automatic prog_wait(int m, int n, int pl, string r);
        fire(0, m, n, pl); wait_done(r);
    endtask

    task automatic chk_final(string r, int m, int n, int pl, int st);
        chk({r, " coef_m"}, coef_m, m);
        chk({r, " coef_n"}, coef_n, n);
        chk({r, " coef_pl"}, coef_pl, pl);
        chk({r, " status"}, status, st);
    endtask

    // Global watchdog: a hung run is a failed check.
    initial begin
        #1500000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cm, cn, cp, m, n, pl, en, nexp;
        int exp[4];
        void'($urandom(32'd4242));
        clear_log();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", pll_en, 0); chk("R1 iddq", pll_iddq, 1);
        chk("R1 lockdet_off", lockdet_off, 1); chk("R1 vco_sel", vco_sel, 0);
        chk("R1 out_div", out_div, 0); chk("R1 busy", busy, 0);
        chk("R1 coef_n", coef_n, 0); chk("R1 done", done, 0);

        // R5 first program from disabled: power-up, reload with nlo(2)
        prog_wait(2, 100, 1, "R5");
        chk("R5 n at enable", n_enr, nlo(2));
        chk("R5 iddq settle", (t_enr - t_iddq) >= WAIT, 1);
        chk("R5 lockdet cleared", lockdet_off, 0);
        chk("R6 ramp up count", nr, 1); chk("R6 ramp up target", rl[0], 100);
        chk("R6 vco selected", vco_sel, 1); chk("R6 div 1:1", out_div, 0);
        chk("R6 div restore wait", (t_div1 - t_vco) >= WAIT, 1);
        chk_final("R11", 2, 100, 1, 0);

        // R2 N-only change
        prog_wait(2, 150, 1, "R2");
        chk("R2 ramps", nr, 1); chk("R2 target", rl[0], 150);
        chk("R2 no divide", t_div2, -1); chk("R2 no bypass", t_byp, -1);
        chk_final("R2", 2, 150, 1, 0);

        // R3 identical request: no ramp
        prog_wait(2, 150, 1, "R3");
        chk("R3 ramps", nr, 0); chk_final("R3", 2, 150, 1, 0);

        // R4 full change from running PLL
        prog_wait(1, 60, 3, "R4");
        chk("R4 ramps", nr, 2); chk("R4 down target", rl[0], nlo(2));
        chk("R4 up target", rl[1], 60); chk("R4 n at enable", n_enr, nlo(1));
        chk("R4 bypass after divide", (t_byp - t_div2) >= WAIT, 1);
        chk_final("R4", 1, 60, 3, 0);

        // R8 ramp timeout then direct retry
        ramp_broken = 1;
        prog_wait(2, 200, 1, "R8");
        ramp_broken = 0;
        chk("R8 ramps", nr, 1); chk("R8 direct N", n_enr, 200);
        chk_final("R8", 2, 200, 1, 0);

        // R7 lock never arrives: two attempts then status 1
        lock_broken = 1;
        prog_wait(3, 90, 2, "R7");
        lock_broken = 0;
        chk("R7 status", status, 1); chk("R7 bypass kept", vco_sel, 0);
        chk("R7 retry N", coef_n, 90); chk("R7 ramps", nr, 1);
        prog_wait(1, 70, 0, "R7b");
        chk("R7 recover ramps", nr, 2); chk("R7 recover down", rl[0], nlo(3));
        chk_final("R7 recover", 1, 70, 0, 0);

        // R10 second request while busy is dropped
        fire(0, 2, 130, 1);
        tgt_m = 3; tgt_n = 40; tgt_pl = 5; req_prog = 1;
        @(negedge clk);
        chk("R10 refused", refused, 1);
        req_prog = 0;
        wait_done("R10");
        chk_final("R10", 2, 130, 1, 0);

        // R9 shutdown from running PLL
        fire(1, 0, 0, 0); wait_done("R9");
        chk("R9 ramps", nr, 1); chk("R9 target", rl[0], nlo(2));
        chk("R9 bypass then off", (t_enf > t_byp) && (t_byp > 0), 1);
        chk("R9 en", pll_en, 0); chk("R9 status", status, 0);

        // R9 shutdown with broken ramp still completes, status 2
        prog_wait(2, 120, 1, "R9b");
        ramp_broken = 1;
        fire(1, 0, 0, 0); wait_done("R9c");
        ramp_broken = 0;
        chk("R9 ramp fail status", status, 2);
        chk("R9 off after fail", pll_en, 0); chk("R9 bypass after fail", vco_sel, 0);

        // R4 saturation of minimum-VCO divider
        prog_wait(4, 200, 0, "R4s");
        chk("R4 saturated n", n_enr, 255); chk_final("R4s", 4, 200, 0, 0);

        // R9 shutdown twice: second one ramps nothing
        fire(1, 0, 0, 0); wait_done("R9d");
        fire(1, 0, 0, 0); wait_done("R9e");
        chk("R9 disabled ramps", nr, 0); chk("R9 disabled status", status, 0);

        // Random programs against a path model (R2 R3 R4 R6)
        prog_wait(2, 100, 1, "R6r");
        cm = 2; cn = 100; cp = 1;
        for (int i = 0; i < 30; i++) begin
            m  = ($urandom % 2) ? cm : 1 + int'($urandom % 3);
            pl = ($urandom % 2) ? cp : int'($urandom % 4);
            n  = 8 + int'($urandom % 248);
            nexp = 0;
            if (m == cm && pl == cp) begin
                if (n != cn) begin exp[0] = n; nexp = 1; end
            end else begin
                if (nlo(cm) != cn) begin exp[nexp] = nlo(cm); nexp++; end
                if (n != nlo(m)) begin exp[nexp] = n; nexp++; end
            end
            prog_wait(m, n, pl, "R4r");
            chk("R4 random ramp count", nr, nexp);
            for (int j = 0; j < nexp; j++) chk("R3 random ramp target", rl[j], exp[j]);
            chk_final("R6 random", m, n, pl, 0);
            chk("R6 random vco", vco_sel, 1);
            cm = m; cn = n; cp = pl;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule